// File: doc/BRIEF.md
# Latched Interrupt Priority Arbiter

This block sits between a set of level-sensitive peripheral interrupt lines, a software-interrupt request raised by an instruction, and a processor core. Each clock it works out whether any request is eligible to be serviced. Hardware lines count only while the core's global mask bit is clear. The software request counts whatever the mask holds. The result is reported on a registered pending flag.

When the core pulses its exception-start strobe and something is eligible, the block runs one fixed-priority arbitration and freezes the result as a vector index. The software request gets index 0 and outranks every hardware line. Hardware line `i` gets index `i+1`, and among those lines the lowest-numbered one wins. After that, no request of any priority can replace the frozen index. The latch is released in one of two ways: the core pulses its service-complete strobe, or the mask bit drops from set to clear, which is how a handler opens itself to nesting. Lines that are still asserted after a release take part in the next arbitration.

Top module: `irq_latch_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `vec_valid`=0, `vec_idx`=0 and `irq_pending`=0.
- R2: After every clock edge out of reset, `irq_pending` is 1 exactly when, at that edge, `swi_req` was 1 or at least one `irq_req` bit was 1 while `mask_i` was 0.
- R3: While `mask_i` is 1, hardware lines alone never make `irq_pending` rise or cause a latch. `swi_req` is not affected by the mask.
- R4: An edge with `take_i`=1, no vector held and an eligible request present sets `vec_valid` to 1 from the next cycle.
- R5: The latched index is 0 when `swi_req` is eligible. Otherwise it is `i+1`, where `i` is the lowest-numbered `irq_req` bit that is set.
- R6: While `vec_valid` is 1, `vec_idx` does not change, whatever happens on the request lines or on further `take_i` pulses.
- R7: An edge with `done_i`=1 while a vector is held makes `vec_valid`=0 and `vec_idx`=0 in the next cycle. Release wins over a `take_i` pulse at the same edge.
- R8: While a vector is held, an edge where `mask_i` is 0 after being 1 at the previous edge releases the vector, with the same timing as R7.
- R9: A `take_i` pulse with no eligible request leaves `vec_valid` at 0.
- R10: Requests are level-sensitive. A line still asserted after a release is latched again by the next `take_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Level-sensitive hardware request lines, bit 0 highest priority |
| swi_req | input | 1 | Software interrupt request, not maskable |
| mask_i | input | 1 | Core global interrupt mask, 1 blocks hardware lines |
| take_i | input | 1 | Core strobe: begin exception processing |
| done_i | input | 1 | Core strobe: service of the held vector complete |
| irq_pending | output | 1 | Registered: an eligible request was present at the last edge |
| vec_valid | output | 1 | A vector index is latched |
| vec_idx | output | IDX_W | Latched index, 0 = software, i+1 = line i; 0 when nothing is held |

## Verification
The bench goes after the freeze first: a higher-priority line or the software request arrives after a lower one has been latched. A design that re-arbitrates continuously would let `vec_idx` jump mid-service. It also drives release and a new `take_i` at the same edge, where a design with the wrong ordering would skip the release or latch a stale winner. A mask that falls while a vector is held must release the latch, and a mask that is merely low must not. Getting that edge detection wrong either leaves the core stuck on the old vector or drops the latch at once. Software requests under a set mask, `take_i` with nothing eligible, and lines held across a release round out the directed cases. These run alongside a long random run checked against a bench model.

// File: rtl/irq_arb_pkg.sv
// Package: shared types for the latched interrupt arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package irq_arb_pkg;

    // Latch state: either free to arbitrate or holding a frozen vector.
    typedef enum logic {
        LATCH_FREE = 1'b0,
        LATCH_HELD = 1'b1
    } latch_state_e;

    // Width of the vector index for a given hardware source count
    // (one extra code for the software request).
    function automatic int idx_width(input int n_src);
        return (n_src < 1) ? 1 : $clog2(n_src + 1);
    endfunction

endpackage

// File: rtl/irq_request_gate.sv
// Module: irq_request_gate
// Applies the global mask to hardware lines, leaves the software request
// untouched, and registers the "something eligible" flag for the core.
// Assumes request lines are synchronous to clk and level-sensitive.
module irq_request_gate #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_req_i,
    input  logic             swi_req_i,
    input  logic             mask_i,
    output logic [N_SRC-1:0] hw_elig_o,
    output logic             swi_elig_o,
    output logic             any_elig_o,
    output logic             pending_o
);

    logic pending_q;

    // Gate each hardware line with the inverted mask, one lane per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_lane
        assign hw_elig_o[g] = hw_req_i[g] & ~mask_i;
    end

    // The software request is never blocked by the mask.
    assign swi_elig_o = swi_req_i;

    // Any eligible request at all, combinational view for the latch.
    assign any_elig_o = swi_elig_o | (|hw_elig_o);

    // Register the pending flag so the core sees a clean, edge-aligned level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= any_elig_o;
        end
    end

    assign pending_o = pending_q;

    // R3: with the mask set, a hardware line alone cannot raise pending.
    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !swi_req_i) |=> !pending_o);

    // R2: pending follows last edge's eligibility of the raw ports.
    assert_pending_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pending_o == ($past(swi_req_i) | ((|$past(hw_req_i)) & ~$past(mask_i)))));

endmodule

// File: rtl/irq_priority_pick.sv
// Module: irq_priority_pick
// Fixed-priority selection: software request first, then the lowest
// numbered hardware line. Produces a one-hot grant and its index.
// Assumes inputs are already gated by the mask.
module irq_priority_pick #(
    parameter int N_SRC = 8,
    parameter int IDX_W = irq_arb_pkg::idx_width(N_SRC)
) (
    input  logic [N_SRC-1:0] hw_elig_i,
    input  logic             swi_elig_i,
    output logic             win_valid_o,
    output logic [IDX_W-1:0] win_idx_o
);

    localparam int N_ALL = N_SRC + 1;   // slot 0 software, slot i+1 line i

    logic [N_ALL-1:0] cand;
    logic [N_ALL-1:0] lower_seen;
    logic [N_ALL-1:0] grant;

    assign cand = {hw_elig_i, swi_elig_i};

    // Prefix chain: lower_seen[k] says a higher-priority slot below k is set.
    assign lower_seen[0] = 1'b0;
    for (genvar k = 1; k < N_ALL; k++) begin : g_prefix
        assign lower_seen[k] = lower_seen[k-1] | cand[k-1];
    end

    // One-hot grant: a slot wins if it asks and nothing ranked above it asks.
    for (genvar k = 0; k < N_ALL; k++) begin : g_grant
        assign grant[k] = cand[k] & ~lower_seen[k];
    end

    // Encode the one-hot grant into the vector index.
    always_comb begin
        win_idx_o = '0;
        for (int k = 0; k < N_ALL; k++) begin
            if (grant[k]) begin
                win_idx_o = IDX_W'(k);
            end
        end
    end

    assign win_valid_o = |cand;

    // R5: the grant is one-hot whenever anything asks, and the winner asks.
    always_comb begin
        if (win_valid_o) begin
            assert_grant_onehot_R5: assert ($countones(grant) == 1);
        end
        if (swi_elig_i) begin
            assert_swi_first_R5: assert (win_idx_o == '0);
        end
    end

endmodule

// File: rtl/irq_grant_latch.sv
// Module: irq_grant_latch
// Freezes one arbitration result on the core's start strobe and holds it
// until the service-complete strobe or a falling edge of the mask.
// Assumes strobes are one-cycle pulses synchronous to clk; a release
// and a start at the same edge resolve to release.
module irq_grant_latch #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             done_i,
    input  logic             mask_i,
    input  logic             win_valid_i,
    input  logic [IDX_W-1:0] win_idx_i,
    output logic             held_o,
    output logic [IDX_W-1:0] idx_o
);

    import irq_arb_pkg::*;

    latch_state_e     state_q;
    logic [IDX_W-1:0] idx_q;
    logic             mask_prev_q;
    logic             mask_fell;
    logic             release_now;
    logic             capture_now;

    // Mask went from set to clear across this edge.
    assign mask_fell   = mask_prev_q & ~mask_i;
    // Release has priority over any capture while a vector is held.
    assign release_now = (state_q == LATCH_HELD) & (done_i | mask_fell);
    // Capture only from the free state and only with something eligible.
    assign capture_now = (state_q == LATCH_FREE) & take_i & win_valid_i;

    // Remember last edge's mask so a falling edge can be recognised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_prev_q <= 1'b0;
        end else begin
            mask_prev_q <= mask_i;
        end
    end

    // State and frozen index: capture, hold, or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LATCH_FREE;
            idx_q   <= '0;
        end else if (release_now) begin
            state_q <= LATCH_FREE;
            idx_q   <= '0;
        end else if (capture_now) begin
            state_q <= LATCH_HELD;
            idx_q   <= win_idx_i;
        end
    end

    assign held_o = (state_q == LATCH_HELD);
    assign idx_o  = idx_q;

    // R6: a held index stays put until released.
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !done_i && !mask_fell) |=> (held_o && $stable(idx_o)));

    // R7: service-complete frees the latch and clears the index.
    assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && done_i) |=> (!held_o && idx_o == '0));

    // R8: a falling mask while held frees the latch.
    assert_mask_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && $past(mask_i) && !mask_i) |=> !held_o);

    // R9: a start strobe with nothing eligible does not latch.
    assert_empty_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && take_i && !win_valid_i) |=> !held_o);

    // R4: a start strobe with something eligible latches.
    assert_take_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && take_i && win_valid_i) |=> held_o);

    // R1: reset empties the latch.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!held_o && idx_o == '0));

endmodule

// File: rtl/irq_latch_arbiter.sv
// Module: irq_latch_arbiter (top)
// Collects maskable hardware lines and a software request, reports a
// pending flag, and on the core's start strobe freezes one fixed-priority
// winner as a vector index until service completes or the mask drops.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module irq_latch_arbiter #(
    parameter int N_SRC = 8,
    parameter int IDX_W = irq_arb_pkg::idx_width(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             swi_req,
    input  logic             mask_i,
    input  logic             take_i,
    input  logic             done_i,
    output logic             irq_pending,
    output logic             vec_valid,
    output logic [IDX_W-1:0] vec_idx
);

    logic [N_SRC-1:0] hw_elig;
    logic             swi_elig;
    logic             any_elig;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    irq_request_gate #(.N_SRC(N_SRC)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_req_i   (irq_req),
        .swi_req_i  (swi_req),
        .mask_i     (mask_i),
        .hw_elig_o  (hw_elig),
        .swi_elig_o (swi_elig),
        .any_elig_o (any_elig),
        .pending_o  (irq_pending)
    );

    irq_priority_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .hw_elig_i   (hw_elig),
        .swi_elig_i  (swi_elig),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    irq_grant_latch #(.IDX_W(IDX_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take_i),
        .done_i      (done_i),
        .mask_i      (mask_i),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .held_o      (vec_valid),
        .idx_o       (vec_idx)
    );

    // R4: arbiter and gate agree on whether anything is eligible.
    always_comb begin
        assert_gate_pick_agree_R4: assert (win_valid == any_elig);
    end

    // R3: under a set mask with no software request nothing new is latched.
    assert_mask_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid && mask_i && !swi_req) |=> !vec_valid);

endmodule

// File: tb/tb_irq_latch_arbiter.sv
// Bench: drives inputs on the falling edge, samples 1 ns after the rising
// edge, and compares against a behavioural model built from the requirements.
module tb_irq_latch_arbiter;

    localparam int N     = 8;
    localparam int IW    = 4;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          swi_req = 1'b0, mask_i = 1'b0, take_i = 1'b0, done_i = 1'b0;
    logic          irq_pending, vec_valid;
    logic [IW-1:0] vec_idx;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state
    logic          m_held = 1'b0, m_pend = 1'b0, m_mprev = 1'b0;
    logic [IW-1:0] m_idx = '0;

    always #2 clk = ~clk;   // 250 MHz

    irq_latch_arbiter #(.N_SRC(N), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
        .mask_i(mask_i), .take_i(take_i), .done_i(done_i),
        .irq_pending(irq_pending), .vec_valid(vec_valid), .vec_idx(vec_idx)
    );

    function automatic logic elig(input logic [N-1:0] r, input logic s, input logic m);
        return s | ((|r) & ~m);
    endfunction

    function automatic logic [IW-1:0] winner(input logic [N-1:0] r, input logic s);
        if (s) return '0;
        for (int i = 0; i < N; i++) if (r[i]) return IW'(i + 1);
        return '0;
    endfunction

    task automatic model_step();
        logic rel;
        if (!rst_n) begin
            m_held = 0; m_idx = '0; m_pend = 0; m_mprev = 0;
        end else begin
            rel = m_held & (done_i | (m_mprev & ~mask_i));
            if (rel) begin
                m_held = 0; m_idx = '0;
            end else if (!m_held && take_i && elig(irq_req, swi_req, mask_i)) begin
                m_held = 1; m_idx = winner(irq_req, swi_req);
            end
            m_pend  = elig(irq_req, swi_req, mask_i);
            m_mprev = mask_i;
        end
    endtask

    task automatic check(input string tag);
        n_tests++;
        if (vec_valid !== m_held || vec_idx !== m_idx || irq_pending !== m_pend) begin
            n_fail++;
            $display("FAIL %s: valid/idx/pend actual %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, vec_valid, vec_idx, irq_pending, m_held, m_idx, m_pend);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic s, input logic m,
                        input logic t, input logic d, input string tag);
        @(negedge clk);
        irq_req = r; swi_req = s; mask_i = m; take_i = t; done_i = d;
        @(posedge clk);
        #1;
        model_step();
        check(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(LIMIT * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        // R1: reset state with busy inputs.
        rst_n = 0;
        step(8'hFF, 1, 0, 1, 0, "R1");
        step(8'h0F, 1, 1, 1, 0, "R1");
        step(8'h00, 0, 0, 0, 0, "R1");
        @(negedge clk); rst_n = 1;
        step(8'h00, 0, 0, 0, 0, "R2");
        // R3: masked hardware alone: no pending, no latch (R9 too).
        step(8'h10, 0, 1, 0, 0, "R3");
        step(8'h10, 0, 1, 1, 0, "R3");
        step(8'h00, 0, 0, 1, 0, "R9");
        // R3/R5: software request under a set mask latches index 0.
        step(8'h04, 1, 1, 1, 0, "R3");
        step(8'h01, 0, 1, 0, 1, "R7");
        // R5: lowest line wins: lines 5 and 2 -> index 3.
        step(8'h24, 0, 0, 1, 0, "R5");
        // R6: higher line and software arrive, index must not move.
        step(8'h25, 1, 0, 1, 0, "R6");
        step(8'h01, 1, 1, 0, 0, "R6");
        // R8: mask falls while held -> release; R10: still-high line re-latched.
        step(8'h01, 0, 0, 0, 0, "R8");
        step(8'h01, 0, 0, 1, 0, "R10");
        // R7: done and take together: release wins.
        step(8'h02, 0, 0, 1, 1, "R7");
        step(8'h02, 0, 0, 1, 0, "R4");
        // Mask merely low while held must not release.
        step(8'h00, 0, 0, 0, 0, "R8");
        step(8'h00, 0, 0, 0, 1, "R7");
        // R2/R6: random traffic against the model.
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] r;
            r = 8'($urandom) & 8'($urandom);
            step(r, ($urandom % 8) == 0,
                 ((c / 23) % 2) == 1 ? (($urandom % 16) != 0) : (($urandom % 16) == 0),
                 ($urandom % 4) == 0, ($urandom % 6) == 0, "R2/R5/R6");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule